// File: doc/BRIEF.md
# Saturating 40-bit Multiply-Accumulate Datapath

This block is the arithmetic core of a signal-processing engine. Each accepted command names one of two 40-bit accumulators and does one of five things to it: loads it with a product, adds a product to it, subtracts a product from it, shifts it, or clears it. Every command completes in one cycle. The product comes from a 17x17 multiplier. Each 16-bit operand is widened by one bit, which is a copy of its sign bit or zero. This lets signed, unsigned and mixed-sign operands share one multiplier. In fractional mode the product is doubled, so two 1.15 values form a 1.31 value whose binary point sits at accumulator bit 31. Each result may be clamped at the full 40-bit range, or at a tighter 32-bit range. Three flags are reported: the result left the 32-bit range, the exact result did not fit 40 bits, or a clamp was applied.

Commands arrive on a valid/ready stream and results leave on a second valid/ready stream. The datapath holds exactly one result. `in_ready` is high when no result is waiting or when the consumer takes the waiting result in the same cycle. When the consumer holds `out_ready` low, the result and its flags stay frozen and no further command is taken. Commands issued back to back on the same accumulator see each other's results without bubbles. Both accumulators are also visible at all times on plain status outputs.

Top module: `mac40_datapath`

## Requirements
- R1: A command is taken when `in_valid` and `in_ready` are both high, with `in_ready = !out_valid || out_ready`. Its result appears on `out_acc` and the flags with `out_valid` high after the next rising edge. While `out_valid && !out_ready`, the outputs hold and `in_ready` is low.
- R2: Operation code 1 (load product) writes the product into the selected accumulator. Each operand is extended to 17 bits with its top bit when its signed flag is 1, and with a zero when its signed flag is 0. In integer mode this command never sets `out_cat`.
- R3: With `in_frac` = 1 the product is shifted left by one before use. With sign-extended operands, 0x8000 x 0x8000 gives exactly 0x0080000000, and `out_cat` stays clear when saturation is off.
- R4: Code 2 adds the product to the selected accumulator and code 3 subtracts it. One such command can be accepted in every cycle, each one building on the previous result.
- R5: With `in_sat` = 0 a result outside the 40-bit signed range wraps modulo 2^40 and sets `out_cat`.
- R6: With `in_sat` = 1 and `in_ssat` = 0, a result outside the 40-bit range is clamped to 0x7FFFFFFFFF or 0x8000000000 according to the sign of the exact result. In that case both `out_sat` and `out_cat` are set.
- R7: With `in_sat` = 1 and `in_ssat` = 1, a result outside the 32-bit signed range is clamped to 0x007FFFFFFF or 0xFF80000000 and sets `out_sat`. `out_ovf` is then clear for codes 0 to 4.
- R8: `out_ovf` is 1 when bits 39 down to 31 of the written value are not all equal.
- R9: Code 4 shifts the selected accumulator by the signed 6-bit amount `in_shift`. Positive amounts shift right arithmetically and negative amounts shift left. Magnitudes above 16 act as 16. A left shift whose exact value leaves the 40-bit range is treated like an arithmetic overflow under R5 to R7, and a right shift never sets `out_cat`.
- R10: `in_sel` = 0 selects accumulator A and 1 selects B, and the other accumulator is never changed. Code 0 writes zero with all flags clear. Codes 5 to 7 leave the accumulator unchanged, report its value and its `out_ovf`, and keep `out_cat` and `out_sat` clear.
- R11: After reset both accumulators and `out_acc` are zero, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command can be taken this cycle |
| in_op | input | 3 | Operation: 0 clear, 1 load product, 2 add product, 3 subtract product, 4 shift, 5-7 read |
| in_sel | input | 1 | Accumulator select: 0 = A, 1 = B |
| in_x | input | 16 | First multiplier operand |
| in_y | input | 16 | Second multiplier operand |
| in_x_signed | input | 1 | `in_x` is signed |
| in_y_signed | input | 1 | `in_y` is signed |
| in_frac | input | 1 | Fractional mode: double the product |
| in_sat | input | 1 | Enable saturation |
| in_ssat | input | 1 | Clamp at the 32-bit range instead of the 40-bit range |
| in_shift | input | 6 | Signed shift amount, positive = right |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_acc | output | 40 | Value written to the selected accumulator |
| out_ovf | output | 1 | Result outside the 32-bit signed range |
| out_cat | output | 1 | Exact result outside the 40-bit signed range |
| out_sat | output | 1 | Clamp applied |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |

## Verification
A wrong accumulator value has no hidden period. It shows on `acc_a` or `acc_b` one edge after the faulty command, and it spreads into every later product sum or shift on that accumulator. A command that writes the wrong accumulator changes the other status output in the same cycle. A wrong extension, doubling or clamp changes `out_acc` and the flags on the very next result. A fault in the hold logic shows as a result that changes, or a command that is taken, while the consumer is stalled.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  typedef enum logic [2:0] {
    OP_CLR = 3'd0,
    OP_MPY = 3'd1,
    OP_MAC = 3'd2,
    OP_MSC = 3'd3,
    OP_SHF = 3'd4
  } mac_op_e;

  localparam int unsigned OP_BITS = 3;
endpackage

// File: rtl/mac40_mult.sv
module mac40_mult #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned PROD_W = 2 * (OP_W + 1) + 1
) (
  input  logic [OP_W-1:0]          x,
  input  logic [OP_W-1:0]          y,
  input  logic                     x_sgn,
  input  logic                     y_sgn,
  input  logic                     frac,
  output logic signed [PROD_W-1:0] prod
);
  localparam int unsigned EW  = OP_W + 1;
  localparam int unsigned RAW = 2 * EW;

  logic signed [EW-1:0]  x_e;
  logic signed [EW-1:0]  y_e;
  logic signed [RAW-1:0] raw;

  // widen each operand by its sign bit or a zero
  assign x_e  = {x_sgn & x[OP_W-1], x};
  assign y_e  = {y_sgn & y[OP_W-1], y};
  assign raw  = x_e * y_e;
  assign prod = frac ? {raw, 1'b0} : {raw[RAW-1], raw};
endmodule

// File: rtl/mac40_shifter.sv
module mac40_shifter #(
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned SH_MAX = 16,
  parameter int unsigned SH_W   = 6,
  parameter int unsigned EXT_W  = ACC_W + SH_MAX + 1
) (
  input  logic [ACC_W-1:0]        acc,
  input  logic [SH_W-1:0]         amt,
  output logic signed [EXT_W-1:0] res
);
  localparam int unsigned LVL = $clog2(SH_MAX + 1);

  logic            left;
  logic [SH_W-1:0] mag_raw;
  logic [SH_W-1:0] mag;
  logic signed [EXT_W-1:0] stg [LVL+1];

  assign left    = amt[SH_W-1];
  assign mag_raw = left ? (~amt + 1'b1) : amt;
  assign mag     = (mag_raw > SH_W'(SH_MAX)) ? SH_W'(SH_MAX) : mag_raw;
  assign stg[0]  = {{(EXT_W-ACC_W){acc[ACC_W-1]}}, acc};

  // logarithmic barrel: one stage per bit of the magnitude
  for (genvar i = 0; i < LVL; i++) begin : g_stage
    assign stg[i+1] = !mag[i] ? stg[i]
                    : left    ? (stg[i] <<< (1 << i))
                              : (stg[i] >>> (1 << i));
  end

  assign res = stg[LVL];
endmodule

// File: rtl/mac40_sat.sv
module mac40_sat #(
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned SSAT_W = 32,
  parameter int unsigned EXT_W  = 57
) (
  input  logic [EXT_W-1:0] exact,
  input  logic             sat_en,
  input  logic             ssat_en,
  input  logic             bypass,
  output logic [ACC_W-1:0] res,
  output logic             cat,
  output logic             hit
);
  localparam logic [ACC_W-1:0] MAX_F = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_F = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] MAX_S = {{(ACC_W-SSAT_W+1){1'b0}}, {(SSAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_S = {{(ACC_W-SSAT_W+1){1'b1}}, {(SSAT_W-1){1'b0}}};

  logic fits_f;
  logic fits_s;
  logic neg;

  assign fits_f = (&exact[EXT_W-1:ACC_W-1]) | ~(|exact[EXT_W-1:ACC_W-1]);
  assign fits_s = (&exact[EXT_W-1:SSAT_W-1]) | ~(|exact[EXT_W-1:SSAT_W-1]);
  assign neg    = exact[EXT_W-1];

  always_comb begin
    res = exact[ACC_W-1:0];
    hit = 1'b0;
    cat = !bypass && !fits_f;
    if (!bypass && sat_en) begin
      if (ssat_en && !fits_s) begin
        res = neg ? MIN_S : MAX_S;
        hit = 1'b1;
      end else if (!fits_f) begin
        res = neg ? MIN_F : MAX_F;
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mac40_datapath.sv
module mac40_datapath #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned SSAT_W = 32,
  parameter int unsigned SH_MAX = 16,
  parameter int unsigned SH_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic             in_sel,
  input  logic [OP_W-1:0]  in_x,
  input  logic [OP_W-1:0]  in_y,
  input  logic             in_x_signed,
  input  logic             in_y_signed,
  input  logic             in_frac,
  input  logic             in_sat,
  input  logic             in_ssat,
  input  logic [SH_W-1:0]  in_shift,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_acc,
  output logic             out_ovf,
  output logic             out_cat,
  output logic             out_sat,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b
);
  import mac40_pkg::*;

  localparam int unsigned PROD_W = 2 * (OP_W + 1) + 1;
  localparam int unsigned EXT_W  = ACC_W + SH_MAX + 1;

  logic                     take;
  logic [ACC_W-1:0]         acc_a_q, acc_b_q, acc_cur;
  logic signed [PROD_W-1:0] prod;
  logic [EXT_W-1:0]         acc_ext, prod_ext, shf_ext, exact;
  logic                     bypass;
  logic [ACC_W-1:0]         res;
  logic                     res_cat, res_hit, res_ovf;
  mac_op_e                  op;

  assign op       = mac_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign acc_cur  = in_sel ? acc_b_q : acc_a_q;
  assign acc_ext  = {{(EXT_W-ACC_W){acc_cur[ACC_W-1]}}, acc_cur};
  assign prod_ext = {{(EXT_W-PROD_W){prod[PROD_W-1]}}, prod};

  mac40_mult #(.OP_W(OP_W), .PROD_W(PROD_W)) u_mult (
    .x(in_x), .y(in_y), .x_sgn(in_x_signed), .y_sgn(in_y_signed),
    .frac(in_frac), .prod(prod)
  );

  mac40_shifter #(.ACC_W(ACC_W), .SH_MAX(SH_MAX), .SH_W(SH_W), .EXT_W(EXT_W)) u_shf (
    .acc(acc_cur), .amt(in_shift), .res(shf_ext)
  );

  always_comb begin
    bypass = 1'b0;
    case (op)
      OP_CLR:  exact = '0;
      OP_MPY:  exact = prod_ext;
      OP_MAC:  exact = acc_ext + prod_ext;
      OP_MSC:  exact = acc_ext - prod_ext;
      OP_SHF:  exact = shf_ext;
      default: begin
        exact  = acc_ext;
        bypass = 1'b1;
      end
    endcase
  end

  mac40_sat #(.ACC_W(ACC_W), .SSAT_W(SSAT_W), .EXT_W(EXT_W)) u_sat (
    .exact(exact), .sat_en(in_sat), .ssat_en(in_ssat), .bypass(bypass),
    .res(res), .cat(res_cat), .hit(res_hit)
  );

  assign res_ovf = !((&res[ACC_W-1:SSAT_W-1]) | ~(|res[ACC_W-1:SSAT_W-1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a_q   <= '0;
      acc_b_q   <= '0;
      out_valid <= 1'b0;
      out_acc   <= '0;
      out_ovf   <= 1'b0;
      out_cat   <= 1'b0;
      out_sat   <= 1'b0;
    end else if (take) begin
      if (in_sel) acc_b_q <= res;
      else        acc_a_q <= res;
      out_valid <= 1'b1;
      out_acc   <= res;
      out_ovf   <= res_ovf;
      out_cat   <= res_cat;
      out_sat   <= res_hit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign acc_a = acc_a_q;
  assign acc_b = acc_b_q;
endmodule

// File: rtl/mac40_checker.sv
module mac40_checker #(
  parameter int unsigned ACC_W = 40,
  parameter int unsigned SH_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic             in_sel,
  input logic             in_sat,
  input logic             in_ssat,
  input logic             in_frac,
  input logic [SH_W-1:0]  in_shift,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_acc,
  input logic             out_ovf,
  input logic             out_cat,
  input logic             out_sat,
  input logic [ACC_W-1:0] acc_a,
  input logic [ACC_W-1:0] acc_b
);
  logic tk;
  assign tk = in_valid && in_ready;

  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_acc) && $stable(out_cat));
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tk |=> out_valid);
  p_mpy_nocat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tk && in_op == 3'd1 && !in_frac |=> !out_cat);
  p_sat_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tk && in_sat && !in_ssat |=> out_sat == out_cat);
  p_nowrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tk && in_sat && !in_ssat && in_op <= 3'd4 |=> !(out_cat && !out_sat));
  p_ssat_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tk && in_sat && in_ssat && in_op <= 3'd4 |=> !out_ovf);
  p_shr_nocat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tk && in_op == 3'd4 && !in_shift[SH_W-1] |=> !out_cat);
  p_keep_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tk && !in_sel |=> $stable(acc_b));
  p_keep_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tk && in_sel |=> $stable(acc_a));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tk && in_op == 3'd0 |=> out_acc == '0 && !out_ovf && !out_cat && !out_sat);
  p_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tk && in_op >= 3'd5 |=> !out_cat && !out_sat);
endmodule

bind mac40_datapath mac40_checker #(.ACC_W(ACC_W), .SH_W(SH_W)) u_mac40_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_sel(in_sel), .in_sat(in_sat), .in_ssat(in_ssat),
  .in_frac(in_frac), .in_shift(in_shift), .out_valid(out_valid),
  .out_ready(out_ready), .out_acc(out_acc), .out_ovf(out_ovf),
  .out_cat(out_cat), .out_sat(out_sat), .acc_a(acc_a), .acc_b(acc_b)
);

// File: tb/test_mac40_datapath.sv
module test_mac40_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sel = 1'b0;
  logic [2:0]  in_op = 3'd0;
  logic [15:0] in_x = '0, in_y = '0;
  logic        in_x_signed = 1'b0, in_y_signed = 1'b0, in_frac = 1'b0;
  logic        in_sat = 1'b0, in_ssat = 1'b0;
  logic [5:0]  in_shift = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_ovf, out_cat, out_sat;
  logic [39:0] out_acc, acc_a, acc_b;

  int checks = 0;
  int fails  = 0;
  bit bp = 1'b0;

  longint m_a = 0, m_b = 0, m_out = 0;
  bit     m_valid = 0, m_ovf = 0, m_cat = 0, m_sat = 0;
  string  m_tag = "R11";
  bit     m_ss = 0;

  always #5 clk = ~clk;

  mac40_datapath i_mac40_datapath (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sel(in_sel), .in_x(in_x), .in_y(in_y),
    .in_x_signed(in_x_signed), .in_y_signed(in_y_signed), .in_frac(in_frac),
    .in_sat(in_sat), .in_ssat(in_ssat), .in_shift(in_shift),
    .out_valid(out_valid), .out_ready(out_ready), .out_acc(out_acc),
    .out_ovf(out_ovf), .out_cat(out_cat), .out_sat(out_sat),
    .acc_a(acc_a), .acc_b(acc_b)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint wrap40(input longint v);
    return (v <<< 24) >>> 24;
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_out = 0; m_valid = 0;
      m_ovf = 0; m_cat = 0; m_sat = 0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      longint x, y, p, acc, ex, res, lim40, lim32;
      int sh;
      bit hold, fit40, fit32;
      lim40 = 64'sd1 <<< 39;
      lim32 = 64'sd1 <<< 31;
      x = in_x_signed ? longint'($signed(in_x)) : longint'(in_x);
      y = in_y_signed ? longint'($signed(in_y)) : longint'(in_y);
      p = x * y;
      if (in_frac) p = p * 2;
      acc = in_sel ? m_b : m_a;
      hold = 0;
      case (in_op)
        3'd0: begin ex = 0; m_tag = "R10"; end
        3'd1: begin ex = p; m_tag = in_frac ? "R3" : "R2"; end
        3'd2: begin ex = acc + p; m_tag = "R4"; end
        3'd3: begin ex = acc - p; m_tag = "R4"; end
        3'd4: begin
          sh = int'($signed(in_shift));
          if (sh > 16) sh = 16;
          if (sh < -16) sh = -16;
          ex = (sh >= 0) ? (acc >>> sh) : (acc <<< (-sh));
          m_tag = "R9";
        end
        default: begin ex = acc; hold = 1; m_tag = "R10"; end
      endcase
      fit40 = (ex >= -lim40) && (ex < lim40);
      fit32 = (ex >= -lim32) && (ex < lim32);
      m_cat = !hold && !fit40;
      m_sat = 0;
      m_ss  = in_ssat;
      if (hold) res = acc;
      else if (in_sat && in_ssat && !fit32) begin
        res = (ex < 0) ? -lim32 : lim32 - 1; m_sat = 1;
      end else if (in_sat && !fit40) begin
        res = (ex < 0) ? -lim40 : lim40 - 1; m_sat = 1;
      end else res = wrap40(ex);
      m_ovf = !((res >= -lim32) && (res < lim32));
      if (in_sel) m_b = res; else m_a = res;
      m_out = res;
      m_valid = 1;
    end else if (out_ready) begin
      m_valid = 0;
    end
  end

  task automatic compare();
    chk(in_ready == (!m_valid || out_ready), "R1 in_ready", longint'(in_ready), longint'(!m_valid || out_ready));
    chk(out_valid == m_valid, "R1 out_valid", longint'(out_valid), longint'(m_valid));
    chk(out_acc == 40'(m_out), {m_tag, " out_acc"}, longint'(out_acc), m_out & 64'hFF_FFFF_FFFF);
    chk(out_ovf == m_ovf, "R8 out_ovf", longint'(out_ovf), longint'(m_ovf));
    chk(out_cat == m_cat, "R5 out_cat", longint'(out_cat), longint'(m_cat));
    chk(out_sat == m_sat, m_ss ? "R7 out_sat" : "R6 out_sat", longint'(out_sat), longint'(m_sat));
    chk(acc_a == 40'(m_a), "R10 acc_a", longint'(acc_a), m_a & 64'hFF_FFFF_FFFF);
    chk(acc_b == 40'(m_b), "R10 acc_b", longint'(acc_b), m_b & 64'hFF_FFFF_FFFF);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
    out_ready = bp ? ($urandom_range(0, 3) != 0) : 1'b1;
  endtask

  task automatic send(input logic [2:0] op, input bit sel, input logic [15:0] x, input logic [15:0] y,
                      input bit xs, input bit ys, input bit fr, input bit sat, input bit ss,
                      input logic [5:0] sh);
    bit acc;
    in_valid = 1'b1; in_op = op; in_sel = sel; in_x = x; in_y = y;
    in_x_signed = xs; in_y_signed = ys; in_frac = fr; in_sat = sat; in_ssat = ss; in_shift = sh;
    do begin
      #1 acc = in_ready;
      cyc();
    end while (!acc);
    in_valid = 1'b0;
  endtask

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R11 handshake", longint'({out_valid, in_ready}), 64'd1);
    chk(acc_a == '0 && acc_b == '0 && out_acc == '0, "R11 accumulators", longint'(acc_a | acc_b), 0);
    rst_n = 1'b1;
    cyc();

    // R2: unsigned 0xFFFF times signed 0xFFFF is -65535
    send(3'd1, 0, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 0, 6'd0);
    chk(acc_a == 40'hFF_FFFF_0001, "R2 mixed sign", longint'(acc_a), 64'hFF_FFFF_0001);
    send(3'd1, 0, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 6'd0);
    chk(acc_a == 40'h00_FFFE_0001, "R2 unsigned", longint'(acc_a), 64'hFFFE_0001);
    // R3: (-1.0) x (-1.0) exact
    send(3'd1, 0, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, 6'd0);
    chk(acc_a == 40'h00_8000_0000 && !out_cat, "R3 minus one squared", longint'(acc_a), 64'h8000_0000);
    chk(out_ovf == 1'b1, "R8 above 1.31", longint'(out_ovf), 1);
    // R7: super-saturation clamps it
    send(3'd1, 0, 16'h8000, 16'h8000, 1, 1, 1, 1, 1, 6'd0);
    chk(acc_a == 40'h00_7FFF_FFFF && out_sat, "R7 clamp high", longint'(acc_a), 64'h7FFF_FFFF);
    // R5: left shift out of range wraps
    send(3'd1, 0, 16'h4001, 16'h4000, 1, 1, 0, 0, 0, 6'd0);
    send(3'd4, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 6'b110000);
    chk(acc_a == 40'h00_4000_0000 && out_cat, "R5 wrap", longint'(acc_a), 64'h4000_0000);
    // R6: same with saturation
    send(3'd1, 0, 16'h4001, 16'h4000, 1, 1, 0, 0, 0, 6'd0);
    send(3'd4, 0, 16'h0, 16'h0, 0, 0, 0, 1, 0, 6'b110000);
    chk(acc_a == 40'h7F_FFFF_FFFF && out_sat && out_cat, "R6 clamp", longint'(acc_a), 64'h7F_FFFF_FFFF);
    // R9: magnitude clamp both ways
    send(3'd1, 0, 16'h0001, 16'h0001, 1, 1, 0, 0, 0, 6'd0);
    send(3'd4, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 6'b100000);
    chk(acc_a == 40'h00_0001_0000, "R9 left clamp", longint'(acc_a), 64'h1_0000);
    send(3'd1, 0, 16'h8000, 16'h0002, 1, 1, 0, 0, 0, 6'd0);
    send(3'd4, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 6'b011111);
    chk(acc_a == 40'hFF_FFFF_FFFF, "R9 right clamp", longint'(acc_a), -1);
    // R10 and R4 on accumulator B
    send(3'd1, 1, 16'd3, 16'd5, 1, 1, 0, 0, 0, 6'd0);
    chk(acc_b == 40'd15 && acc_a == 40'hFF_FFFF_FFFF, "R10 select B", longint'(acc_b), 15);
    send(3'd2, 1, 16'd3, 16'd5, 1, 1, 0, 0, 0, 6'd0);
    send(3'd3, 1, 16'd2, 16'd4, 1, 1, 0, 0, 0, 6'd0);
    chk(acc_b == 40'd22, "R4 add then subtract", longint'(acc_b), 22);
    send(3'd6, 1, 16'd0, 16'd0, 0, 0, 0, 1, 1, 6'd0);
    chk(out_acc == 40'd22 && !out_sat, "R10 read", longint'(out_acc), 22);
    send(3'd0, 1, 16'd0, 16'd0, 0, 0, 0, 0, 0, 6'd0);
    chk(acc_b == '0, "R10 clear", longint'(acc_b), 0);

    // random phase with back-pressure, R1 and all ops against the model
    bp = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      logic [2:0]  op;
      logic [15:0] x, y;
      int k;
      k = $urandom_range(0, 15);
      op = (k < 5) ? 3'd2 : (k < 7) ? 3'd3 : (k < 10) ? 3'd4 : (k < 12) ? 3'd1 :
           (k < 13) ? 3'd0 : 3'(5 + $urandom_range(0, 2));
      x = ($urandom_range(0, 3) == 0) ? 16'h8000 : 16'($urandom);
      y = ($urandom_range(0, 3) == 0) ? 16'h7FFF : 16'($urandom);
      send(op, 1'($urandom), x, y, 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 6'($urandom_range(0, 40)) - 6'd20);
      if ($urandom_range(0, 3) == 0) cyc();
    end
    bp = 1'b0;
    repeat (3) cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule